// File: doc/BRIEF.md
# Predicated Remapped Vector Element Sequencer

This block steps the element loop of one vector instruction. Each enabled cycle it works on one position of the loop and produces three register numbers: one destination and two sources. A position is an outer element `i`, which runs from the start index up to the vector length. When sub-vectors are in use, it is also an inner sub-element `j`. A predicate mask decides per outer element whether anything is issued, and the decision applies to every sub-element of that element. Each operand can be a vector, which advances with the loop, or a scalar, which stays on its base register.

A vector operand may send its flat element number `i*S+j` (S is the sub-vector size) through a remap function before the number is added to the operand's base register. The destination and the two sources each pick their own remap slot from four shape slots. Each slot describes a small 2D array that is walked either in linear order or in transposed order. The flat number is taken modulo the array size.

The current outer index is always visible. An interrupted instruction can therefore be restarted from that index with a resume pulse. A register number that lands beyond the 128-entry register file stops the loop with a fault. A scalar destination ends the loop after its first issue.

Top module: `vec_loop_seq`

## Requirements
- R1: While reset is asserted and until the first start or resume, `issue`, `done` and `fault` are 0 and `saved_idx` is 0.
- R2: Each cycle with `step_en`=1 in the running state performs exactly one step. Outer elements `i` are visited in increasing order. An element whose `pred_mask[i]` is 0 takes one step and issues nothing. `issue` is never 1 while `step_en` is 0.
- R3: `sub_cnt_m1` holds S-1 (code 0..3 for S = 1..4). A predicated-on element issues S times in consecutive steps, with j = 0..S-1, and uses the flat number i*S+j. One predicate bit covers all S of them.
- R4: Bit 0 of `vec_flags` marks the destination as a vector, bit 1 marks source 1 and bit 2 marks source 2. An operand whose bit is 0 reports exactly its base register on every issue.
- R5: If the destination is scalar, the loop enters the done state right after its first issue, and `saved_idx` keeps that element's index.
- R6: `saved_idx` shows the current outer index at all times. A `resume` pulse restarts the loop at `resume_idx` with j=0. `start` restarts it at 0 and takes priority over `resume`.
- R7: If any operand's base plus offset is 128 or more, that step issues nothing. The block then holds `fault`=1, with `saved_idx` fixed at the faulting element, until the next start or resume.
- R8: Each operand has a 3-bit selection: bit 2 enables the remap and bits 1:0 pick a slot. Slot s sits in `shape_cfg[7s+6:7s]`. In a slot, bits 2:0 hold X-1, bits 5:3 hold Y-1 and bit 6 selects transposed order. With k = n mod (X*Y) for flat number n, the offset is k in linear order. In transposed order it is x + y*X, where k counts positions with y varying fastest. A vector operand with the remap disabled uses n itself.
- R9: Once `i` reaches `vl`, the next enabled step enters done with `saved_idx`=`vl`. `done` and `fault` are never 1 together, and `done` holds until the next start or resume. If `vl`=0, the loop completes in one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Allows one loop step this cycle |
| start | input | 1 | Begin the loop at element 0 |
| resume | input | 1 | Begin the loop at `resume_idx` |
| resume_idx | input | 7 | Outer index to restart from |
| vl | input | 7 | Vector length (0..64) |
| sub_cnt_m1 | input | 2 | Sub-vector size minus one |
| pred_mask | input | 64 | Per-element predicate |
| vec_flags | input | 3 | Vector flags: destination, source 1, source 2 |
| base_rd | input | 7 | Destination base register |
| base_rs1 | input | 7 | Source 1 base register |
| base_rs2 | input | 7 | Source 2 base register |
| sel_rd | input | 3 | Destination remap selection |
| sel_rs1 | input | 3 | Source 1 remap selection |
| sel_rs2 | input | 3 | Source 2 remap selection |
| shape_cfg | input | 28 | Four 7-bit shape slots |
| issue | output | 1 | Operation strobe for this step |
| rd_num | output | 7 | Destination register number |
| rs1_num | output | 7 | Source 1 register number |
| rs2_num | output | 7 | Source 2 register number |
| done | output | 1 | Loop finished |
| saved_idx | output | 7 | Current or stopping outer index |
| fault | output | 1 | Register file overrun |

## Verification
Because the outputs come straight from the counters, a wrong sub-element or outer count appears in the register numbers on the very next issue. A wrong count is also caught at the end, when the number of enabled steps and the final `saved_idx` are compared with the model. A bad predicate decision shows up as an extra or missing strobe within one step. A wrong stop state shows up one cycle after the terminating step, in `done` or `fault` and in whether `saved_idx` stays fixed. Random lengths, masks, flags, bases and shapes are mixed with directed cases for a zero length, full sub-vectors, a scalar destination, a resume, an overrun and a transposed shape.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int SHAPE_W = 7;
  localparam int SEL_W   = 3;
  localparam int N_OPS   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_FLT  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/vls_rst_sync.sv
module vls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/vls_remap_unit.sv
module vls_remap_unit #(
  parameter int ID_W    = 9,
  parameter int REG_W   = 7,
  parameter int NREGS   = 128,
  parameter int NSLOT   = 4
) (
  input  logic                                 is_vec,
  input  logic [vls_pkg::SEL_W-1:0]            sel,
  input  logic [REG_W-1:0]                     base,
  input  logic [ID_W-1:0]                      elem_id,
  input  logic [NSLOT*vls_pkg::SHAPE_W-1:0]    shape_cfg,
  output logic [REG_W-1:0]                     reg_num,
  output logic                                 overrun
);
  localparam int SUM_W  = ((ID_W > REG_W) ? ID_W : REG_W) + 1;
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [vls_pkg::SHAPE_W-1:0] cfg;
  logic [ID_W-1:0] xlen, ylen, tot, k, yk, xk, mapped, offs;
  logic [SUM_W-1:0] sum;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot = sel[SLOT_W-1:0];
    cfg  = shape_cfg[slot*vls_pkg::SHAPE_W +: vls_pkg::SHAPE_W];
    xlen = ID_W'(cfg[2:0]) + ID_W'(1);
    ylen = ID_W'(cfg[5:3]) + ID_W'(1);
    tot  = ID_W'(xlen * ylen);
    k    = elem_id % tot;
    yk   = k % ylen;
    xk   = k / ylen;
    if (cfg[6]) mapped = ID_W'(xk + yk * xlen);
    else        mapped = k;
    if (!is_vec)      offs = '0;
    else if (!sel[2]) offs = elem_id;
    else              offs = mapped;
    sum     = SUM_W'(base) + SUM_W'(offs);
    overrun = (sum >= SUM_W'(NREGS));
    reg_num = sum[REG_W-1:0];
  end
endmodule

// File: rtl/vls_elem_ctrl.sv
module vls_elem_ctrl #(
  parameter int MAXVL = 64,
  parameter int CNT_W = 7,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             start,
  input  logic             resume,
  input  logic [CNT_W-1:0] resume_idx,
  input  logic [CNT_W-1:0] vl,
  input  logic [SUB_W-1:0] sub_cnt_m1,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic             dest_vec,
  input  logic             overrun,
  output logic [CNT_W-1:0] elem_q,
  output logic [SUB_W-1:0] sub_q,
  output logic             issue,
  output logic             done,
  output logic             fault
);
  import vls_pkg::*;
  localparam int PIDX_W = (MAXVL > 1) ? $clog2(MAXVL) : 1;

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] elem_d;
  logic [SUB_W-1:0] sub_d;
  logic             load_en;
  logic             live, pbit;

  always_comb begin
    live = (elem_q < vl);
    pbit = 1'b0;
    if (elem_q < CNT_W'(MAXVL)) pbit = pred_mask[elem_q[PIDX_W-1:0]];
  end

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    sub_d   = sub_q;
    issue   = 1'b0;
    if (start) begin
      state_d = ST_RUN;
      elem_d  = '0;
      sub_d   = '0;
    end else if (resume) begin
      state_d = ST_RUN;
      elem_d  = resume_idx;
      sub_d   = '0;
    end else if (state_q == ST_RUN && step_en) begin
      if (!live) begin
        state_d = ST_DONE;
      end else if (!pbit) begin
        elem_d = elem_q + CNT_W'(1);
        sub_d  = '0;
      end else if (overrun) begin
        state_d = ST_FLT;
      end else begin
        issue = 1'b1;
        if (!dest_vec) begin
          state_d = ST_DONE;
        end else if (sub_q == sub_cnt_m1) begin
          elem_d = elem_q + CNT_W'(1);
          sub_d  = '0;
        end else begin
          sub_d = sub_q + SUB_W'(1);
        end
      end
    end
  end

  assign load_en = start | resume | (step_en & (state_q == ST_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      sub_q   <= '0;
    end else if (load_en) begin
      state_q <= state_d;
      elem_q  <= elem_d;
      sub_q   <= sub_d;
    end
  end

  assign done  = (state_q == ST_DONE);
  assign fault = (state_q == ST_FLT);
endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq #(
  parameter int MAXVL = 64,
  parameter int REG_W = 7,
  parameter int NREGS = 128,
  parameter int SUB_W = 2,
  parameter int NSLOT = 4,
  parameter int CNT_W = $clog2(MAXVL + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               step_en,
  input  logic                               start,
  input  logic                               resume,
  input  logic [CNT_W-1:0]                   resume_idx,
  input  logic [CNT_W-1:0]                   vl,
  input  logic [SUB_W-1:0]                   sub_cnt_m1,
  input  logic [MAXVL-1:0]                   pred_mask,
  input  logic [2:0]                         vec_flags,
  input  logic [REG_W-1:0]                   base_rd,
  input  logic [REG_W-1:0]                   base_rs1,
  input  logic [REG_W-1:0]                   base_rs2,
  input  logic [2:0]                         sel_rd,
  input  logic [2:0]                         sel_rs1,
  input  logic [2:0]                         sel_rs2,
  input  logic [NSLOT*vls_pkg::SHAPE_W-1:0]  shape_cfg,
  output logic                               issue,
  output logic [REG_W-1:0]                   rd_num,
  output logic [REG_W-1:0]                   rs1_num,
  output logic [REG_W-1:0]                   rs2_num,
  output logic                               done,
  output logic [CNT_W-1:0]                   saved_idx,
  output logic                               fault
);
  import vls_pkg::*;
  localparam int ID_W = CNT_W + SUB_W;

  logic                  rst_n_sync;
  logic [CNT_W-1:0]      elem_q;
  logic [SUB_W-1:0]      sub_q;
  logic [ID_W-1:0]       flat_id;
  logic [REG_W-1:0]      base_a [N_OPS];
  logic [SEL_W-1:0]      sel_a  [N_OPS];
  logic [REG_W-1:0]      num_a  [N_OPS];
  logic [N_OPS-1:0]      ovr_a;
  logic                  any_ovr;

  vls_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign flat_id = ID_W'(elem_q * (ID_W'(sub_cnt_m1) + ID_W'(1))) + ID_W'(sub_q);

  assign base_a[0] = base_rd;
  assign base_a[1] = base_rs1;
  assign base_a[2] = base_rs2;
  assign sel_a[0]  = sel_rd;
  assign sel_a[1]  = sel_rs1;
  assign sel_a[2]  = sel_rs2;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    vls_remap_unit #(
      .ID_W  (ID_W),
      .REG_W (REG_W),
      .NREGS (NREGS),
      .NSLOT (NSLOT)
    ) u_map (
      .is_vec    (vec_flags[g]),
      .sel       (sel_a[g]),
      .base      (base_a[g]),
      .elem_id   (flat_id),
      .shape_cfg (shape_cfg),
      .reg_num   (num_a[g]),
      .overrun   (ovr_a[g])
    );
  end

  assign any_ovr = |ovr_a;

  vls_elem_ctrl #(
    .MAXVL (MAXVL),
    .CNT_W (CNT_W),
    .SUB_W (SUB_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .step_en    (step_en),
    .start      (start),
    .resume     (resume),
    .resume_idx (resume_idx),
    .vl         (vl),
    .sub_cnt_m1 (sub_cnt_m1),
    .pred_mask  (pred_mask),
    .dest_vec   (vec_flags[0]),
    .overrun    (any_ovr),
    .elem_q     (elem_q),
    .sub_q      (sub_q),
    .issue      (issue),
    .done       (done),
    .fault      (fault)
  );

  assign rd_num    = num_a[0];
  assign rs1_num   = num_a[1];
  assign rs2_num   = num_a[2];
  assign saved_idx = elem_q;
endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
  parameter int CNT_W = 7,
  parameter int REG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic             start,
  input logic             resume,
  input logic [2:0]       vec_flags,
  input logic [REG_W-1:0] base_rs1,
  input logic [REG_W-1:0] base_rs2,
  input logic [REG_W-1:0] rs1_num,
  input logic [REG_W-1:0] rs2_num,
  input logic             issue,
  input logic             done,
  input logic             fault,
  input logic [CNT_W-1:0] saved_idx
);
  assert_stall_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> !issue);

  assert_scalar_src1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !vec_flags[1]) |-> rs1_num == base_rs1);

  assert_scalar_src2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !vec_flags[2]) |-> rs2_num == base_rs2);

  assert_scalar_dest_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !vec_flags[0]) |=> done);

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (saved_idx == $past(saved_idx)) || (saved_idx == $past(saved_idx) + CNT_W'(1)));

  assert_fault_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !issue);

  assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !start && !resume) |=> (fault && $stable(saved_idx)));

  assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !resume) |=> done);
endmodule

bind vec_loop_seq vls_checker #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .start     (start),
  .resume    (resume),
  .vec_flags (vec_flags),
  .base_rs1  (base_rs1),
  .base_rs2  (base_rs2),
  .rs1_num   (rs1_num),
  .rs2_num   (rs2_num),
  .issue     (issue),
  .done      (done),
  .fault     (fault),
  .saved_idx (saved_idx)
);

// File: tb/vec_loop_seq_tb_top.sv
`timescale 1ns/1ps
module vec_loop_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en, start, resume;
  logic [6:0]  resume_idx, vl;
  logic [1:0]  sub_cnt_m1;
  logic [63:0] pred_mask;
  logic [2:0]  vec_flags, sel_rd, sel_rs1, sel_rs2;
  logic [6:0]  base_rd, base_rs1, base_rs2;
  logic [27:0] shape_cfg;
  logic        issue, done, fault;
  logic [6:0]  rd_num, rs1_num, rs2_num, saved_idx;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [20:0] exp_q[$];
  bit  exp_fault;
  int  exp_end, exp_steps;

  always #2.5 clk = ~clk;

  vec_loop_seq dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_map(input logic [2:0] sel, input int id);
    logic [6:0] c;
    int xs, ys, k, pos;
    if (!sel[2]) return id;
    c  = shape_cfg[sel[1:0]*7 +: 7];
    xs = int'(c[2:0]) + 1;
    ys = int'(c[5:3]) + 1;
    k  = id % (xs * ys);
    if (!c[6]) return k;
    pos = 0;
    for (int x = 0; x < xs; x++)
      for (int y = 0; y < ys; y++) begin
        if (pos == k) return x + y * xs;
        pos++;
      end
    return 0;
  endfunction

  task automatic build_exp(input bit use_res, input int ridx);
    int i, j, s, id, r0, r1, r2;
    exp_q.delete();
    exp_fault = 0; exp_steps = 0;
    i = use_res ? ridx : 0; j = 0; s = int'(sub_cnt_m1) + 1;
    forever begin
      exp_steps++;
      if (i >= int'(vl)) begin exp_end = i; break; end
      if (!pred_mask[i]) begin i++; j = 0; continue; end
      id = i * s + j;
      r0 = int'(base_rd)  + (vec_flags[0] ? model_map(sel_rd,  id) : 0);
      r1 = int'(base_rs1) + (vec_flags[1] ? model_map(sel_rs1, id) : 0);
      r2 = int'(base_rs2) + (vec_flags[2] ? model_map(sel_rs2, id) : 0);
      if (r0 > 127 || r1 > 127 || r2 > 127) begin exp_fault = 1; exp_end = i; break; end
      exp_q.push_back({r0[6:0], r1[6:0], r2[6:0]});
      if (!vec_flags[0]) begin exp_end = i; break; end
      if (j == s - 1) begin i++; j = 0; end else j++;
    end
  endtask

  task automatic run_instr(input string tag, input bit use_res, input int ridx, input bit rnd_en);
    int k, steps, cyc;
    logic [6:0] hold;
    build_exp(use_res, ridx);
    @(negedge clk);
    start = !use_res; resume = use_res; resume_idx = 7'(ridx); step_en = 1'b1;
    @(negedge clk);
    start = 1'b0; resume = 1'b0;
    k = 0; steps = 0; cyc = 0;
    while (!done && !fault && cyc < 3000) begin
      step_en = rnd_en ? (($urandom % 4) != 0) : 1'b1;
      #1;
      if (!step_en) chk(!issue, {tag, " R2 stall"}, issue, 0);
      if (issue) begin
        if (k < exp_q.size())
          chk({rd_num, rs1_num, rs2_num} == exp_q[k], {tag, " R3/R8 regs"},
              {rd_num, rs1_num, rs2_num}, exp_q[k]);
        else
          chk(0, {tag, " R2 extra issue"}, k, exp_q.size());
        k++;
      end
      if (step_en) steps++;
      @(negedge clk);
      cyc++;
    end
    step_en = 1'b1;
    #1;
    chk(k == exp_q.size(), {tag, " R2 issue count"}, k, exp_q.size());
    chk(steps == exp_steps, {tag, " R2 step count"}, steps, exp_steps);
    chk(fault == exp_fault, {tag, " R7 fault"}, fault, exp_fault);
    chk(done == !exp_fault, {tag, " R9 done"}, done, !exp_fault);
    chk(int'(saved_idx) == exp_end, {tag, " R6 saved_idx"}, saved_idx, exp_end);
    if (fault) begin
      hold = saved_idx;
      repeat (3) begin
        @(negedge clk); #1;
        chk(fault && !issue && saved_idx == hold, {tag, " R7 hold"}, {fault, issue, saved_idx}, {1'b1, 1'b0, hold});
      end
    end
  endtask

  task automatic plain_cfg;
    sub_cnt_m1 = 2'd0; pred_mask = '1; vec_flags = 3'b111;
    base_rd = 7'd0; base_rs1 = 7'd32; base_rs2 = 7'd64;
    sel_rd = 3'd0; sel_rs1 = 3'd0; sel_rs2 = 3'd0; shape_cfg = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; step_en = 1'b0; start = 1'b0; resume = 1'b0;
    resume_idx = '0; vl = '0; plain_cfg();
    repeat (3) @(negedge clk);
    #1;
    chk(!issue && !done && !fault && saved_idx == 0, "R1 reset", {issue, done, fault, saved_idx}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!issue && !done && !fault && saved_idx == 0, "R1 idle after reset", {issue, done, fault, saved_idx}, 0);

    // R9: zero length completes in one step
    plain_cfg(); vl = 7'd0;
    run_instr("R9 vl0", 0, 0, 0);
    // R3: four sub-elements, elements 0 and 2 predicated on
    plain_cfg(); vl = 7'd3; sub_cnt_m1 = 2'd3; pred_mask = 64'b101;
    run_instr("R3 subvl4", 0, 0, 0);
    // R4: scalar source 1 stays on its base
    plain_cfg(); vl = 7'd6; vec_flags = 3'b101;
    run_instr("R4 scalar src", 0, 0, 1);
    // R5: scalar destination ends after first issue (element 2)
    plain_cfg(); vl = 7'd8; vec_flags = 3'b110; pred_mask = 64'hFC;
    run_instr("R5 scalar dest", 0, 0, 0);
    // R6: resume mid-way
    plain_cfg(); vl = 7'd9; sub_cnt_m1 = 2'd1;
    run_instr("R6 resume", 1, 5, 1);
    // R7: destination overruns at element 2
    plain_cfg(); vl = 7'd5; base_rd = 7'd126;
    run_instr("R7 overrun", 0, 0, 0);
    // R8: transposed 2x3 shape in slot 2 on source 1, linear slot 1 on source 2
    plain_cfg(); vl = 7'd8;
    shape_cfg[14 +: 7] = {1'b1, 3'd2, 3'd1};
    shape_cfg[7 +: 7]  = {1'b0, 3'd1, 3'd1};
    sel_rs1 = 3'b110; sel_rs2 = 3'b101;
    run_instr("R8 transpose", 0, 0, 1);
    // R9: full length
    plain_cfg(); vl = 7'd64; base_rs1 = 7'd0; base_rs2 = 7'd0;
    run_instr("R9 full", 0, 0, 1);

    for (int n = 0; n < 60; n++) begin
      vl = (n % 8 == 7) ? 7'd64 : 7'($urandom % 21);
      sub_cnt_m1 = 2'($urandom % 4);
      pred_mask = (n % 5 == 0) ? '1 : {$urandom, $urandom};
      vec_flags = {1'($urandom), 1'($urandom), 1'(($urandom % 5) != 0)};
      base_rd  = (($urandom % 3) == 0) ? 7'(100 + $urandom % 28) : 7'($urandom % 64);
      base_rs1 = 7'($urandom % 64);
      base_rs2 = 7'($urandom % 64);
      sel_rd = 3'($urandom); sel_rs1 = 3'($urandom); sel_rs2 = 3'($urandom);
      shape_cfg = 28'($urandom);
      if (($urandom % 4) == 0) run_instr("R6 random resume", 1, int'($urandom % (int'(vl) + 1)), 1);
      else                     run_instr("R2 random", 0, 0, 1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule